// File: doc/BRIEF.md
# Gated SD Card Clock Generator

This block derives the card clock of an SD host controller from the peripheral bus clock. An 8-bit select field picks a power-of-two divider from 2 to 512, or passes the bus clock straight through. An output-enable bit holds the card clock pin low while it is clear. An automatic-gating bit limits the clock to command sequences. With gating on, the clock stays low until the command sequencer pulses a start strobe. It then runs until a completion strobe arrives, continues for a fixed number of trailing card-clock cycles (eight by default), and parks low.

The clock control word is written and read through a simple strobe-and-data port. A write-permission input from the host core locks the divider select and the output-enable bit while a clock change is unsafe. Outside the bypass code, the divided clock only stops at the end of a high phase and always restarts with a full low phase, so the card never sees a shortened pulse. A new divider select is adopted at the next falling edge of the divided clock.

Top module: `sdcard_clkgen`

## Requirements
- R1: After reset, the read word is 0x00000020 (select = divide by 128, output enable off, auto gating off) and card_clk is low.
- R2: The control word places the select in bits 7:0, the output enable in bit 8 and the auto-gating enable in bit 9. Bits 31:10 always read as 0, and writing ones to them has no effect.
- R3: While wr_allow is 0, a write leaves bits 8:0 unchanged but still updates bit 9.
- R4: With the output enabled and gating off, select 0x00 gives high and low phases of 1 bus cycle each. A select with only bit i set (i = 0..7) gives phases of 2^(i+1) bus cycles each, which divides the bus clock by 4 through 512.
- R5: Select 0xFF with the output enabled makes card_clk follow the bus clock: high while clk is high and low while clk is low.
- R6: Any select value other than 0x00, 0xFF or a single set bit gives phases of 64 bus cycles each (divide by 128).
- R7: With the output enable at 0, card_clk stays low, whatever the auto-gating bit and the command strobes do.
- R8: With auto gating on, card_clk stays low until cmd_start. The first rising edge then follows the strobe's clock edge after exactly one low phase of the selected length.
- R9: With auto gating on, card_clk shows exactly TRAIL_CYCLES (default 8) more rising edges after the clock edge that takes in cmd_done, and then stays low.
- R10: A cmd_start during the trailing window cancels the pending stop, and the clock keeps running until a later cmd_done.
- R11: A select change written during a high phase lets that high phase finish at its old length, and the following low phase uses the new length.
- R12: Clearing the output enable during a high phase lets that high phase finish at full length, after which card_clk stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| wr_allow | input | 1 | 1 permits updates of the select and output enable |
| reg_rdata | output | 32 | Control word read data |
| cmd_start | input | 1 | One-cycle pulse when a command is issued |
| cmd_done | input | 1 | One-cycle pulse when a command sequence completes |
| card_clk | output | 1 | Card clock pin level |

## Verification
The bench builds the block with its default parameters: an 8-bit select, bypass support on, and an eight-cycle trailing window. It sweeps every legal divider code plus several illegal ones, measuring complete high and low phase lengths in bus cycles up to divide by 512. Because the window is eight cycles and divide by 2 is available, the start, stop and cancel sequences of automatic gating finish within a few dozen cycles. The long divide-by-512 phase leaves room to change the select or clear the enable in the middle of a high phase and observe when the change takes effect.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   localparam int SEL_W     = 8;
   localparam int K_W       = $clog2(SEL_W + 1);
   localparam int CNT_W     = SEL_W;
   localparam logic [SEL_W-1:0] RESET_SEL  = 8'h20;
   localparam logic [SEL_W-1:0] BYPASS_SEL = {SEL_W{1'b1}};
   localparam logic [K_W-1:0]   DEFAULT_K  = K_W'($clog2(RESET_SEL) + 1);

   typedef enum logic [1:0] {
      G_IDLE  = 2'd0,
      G_RUN   = 2'd1,
      G_TRAIL = 2'd2
   } gate_st_t;

   // Returns the exponent k of the half period (2**k bus cycles).
   function automatic logic [K_W-1:0] code_to_k(input logic [SEL_W-1:0] sel);
      logic [K_W-1:0] k;
      k = DEFAULT_K;
      if (sel == '0) k = '0;
      for (int i = 0; i < SEL_W; i++) begin
         if (sel == (SEL_W'(1) << i)) k = K_W'(i + 1);
      end
      return k;
   endfunction

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
   import sdclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [9:0]       wdata,
   input  logic             wr_allow,
   output logic [SEL_W-1:0] sel,
   output logic             out_en,
   output logic             auto_en,
   output logic [31:0]      rdata
);

   logic [SEL_W-1:0] sel_q;
   logic             en_q;
   logic             auto_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= RESET_SEL;
         en_q   <= 1'b0;
         auto_q <= 1'b0;
      end else if (wr) begin
         if (wr_allow) begin
            sel_q <= wdata[SEL_W-1:0];
            en_q  <= wdata[8];
         end
         auto_q <= wdata[9];
      end
   end

   assign sel     = sel_q;
   assign out_en  = en_q;
   assign auto_en = auto_q;
   assign rdata   = {22'd0, auto_q, en_q, sel_q};

   // R3
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wr_allow) |=> ($stable(sel_q) && $stable(en_q)));

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
   import sdclk_pkg::*;
#(
   parameter bit BYPASS_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             run,
   output logic             card_o,
   output logic             rise_o
);

   logic             byp;
   logic [K_W-1:0]   new_k;
   logic [K_W-1:0]   cur_k;
   logic [CNT_W-1:0] cnt;
   logic             div_q;
   logic [CNT_W:0]   half_full;
   logic [CNT_W-1:0] half_m1;
   logic             phase_end;

   generate
      if (BYPASS_EN) begin : g_byp
         assign byp = (sel == BYPASS_SEL);
      end else begin : g_nobyp
         assign byp = 1'b0;
      end
   endgenerate

   assign new_k     = code_to_k(sel);
   assign half_full = (CNT_W+1)'(1) << cur_k;
   assign half_m1   = CNT_W'(half_full - 1'b1);
   assign phase_end = (cnt == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= 1'b0;
         cnt   <= '0;
         cur_k <= DEFAULT_K;
      end else if (byp || (!div_q && !run)) begin
         div_q <= 1'b0;
         cnt   <= '0;
         cur_k <= new_k;
      end else if (phase_end) begin
         cnt   <= '0;
         div_q <= ~div_q;
         if (div_q) cur_k <= new_k;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign rise_o = byp ? run : (!div_q && run && phase_end);
   assign card_o = byp ? (clk & run) : div_q;

   // Checker-side length of the current high phase.
   logic [CNT_W:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_len <= '0;
      else if (div_q) hi_len <= hi_len + 1'b1;
      else            hi_len <= '0;
   end

   // R12
   full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(div_q) && !$past(byp)) |-> (hi_len == $past(half_full)));

   // R7
   parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !div_q) |=> !div_q);

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate
   import sdclk_pkg::*;
#(
   parameter int TRAIL_CYCLES = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_start,
   input  logic cmd_done,
   input  logic rise,
   output logic active
);

   localparam int TW = $clog2(TRAIL_CYCLES + 1);
   localparam logic [TW-1:0] LAST = TW'(TRAIL_CYCLES - 1);

   gate_st_t      st;
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= G_IDLE;
         tcnt <= '0;
      end else begin
         case (st)
            G_IDLE: if (cmd_start) st <= G_RUN;
            G_RUN: begin
               if (cmd_done && !cmd_start) begin
                  st   <= G_TRAIL;
                  tcnt <= '0;
               end
            end
            G_TRAIL: begin
               if (cmd_start) begin
                  st <= G_RUN;
               end else if (rise) begin
                  if (tcnt == LAST) st <= G_IDLE;
                  else              tcnt <= tcnt + 1'b1;
               end
            end
            default: st <= G_IDLE;
         endcase
      end
   end

   assign active = (st != G_IDLE);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == G_IDLE && !cmd_start) |=> (st == G_IDLE));

   // R9
   trail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == G_TRAIL) |-> (tcnt <= LAST));

   // R10
   cancel_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == G_TRAIL && cmd_start) |=> (st == G_RUN));

endmodule

// File: rtl/sdcard_clkgen.sv
module sdcard_clkgen
   import sdclk_pkg::*;
#(
   parameter int TRAIL_CYCLES = 8,
   parameter bit BYPASS_EN    = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   input  logic        wr_allow,
   output logic [31:0] reg_rdata,
   input  logic        cmd_start,
   input  logic        cmd_done,
   output logic        card_clk
);

   generate
      if (TRAIL_CYCLES < 1) begin : g_bad_trail
         $error("TRAIL_CYCLES must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] sel;
   logic             out_en;
   logic             auto_en;
   logic             gate_on;
   logic             run;
   logic             rise;
   logic             unused_hi;

   assign unused_hi = ^reg_wdata[31:10];

   sdclk_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .wdata    (reg_wdata[9:0]),
      .wr_allow (wr_allow),
      .sel      (sel),
      .out_en   (out_en),
      .auto_en  (auto_en),
      .rdata    (reg_rdata)
   );

   sdclk_gate #(.TRAIL_CYCLES(TRAIL_CYCLES)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_done  (cmd_done),
      .rise      (rise),
      .active    (gate_on)
   );

   assign run = out_en && (!auto_en || gate_on);

   sdclk_divider #(.BYPASS_EN(BYPASS_EN)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .run    (run),
      .card_o (card_clk),
      .rise_o (rise)
   );

endmodule

// File: tb/sdcard_clkgen_bench.sv
module sdcard_clkgen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        wr_allow = 1'b1;
   logic [31:0] reg_rdata;
   logic        cmd_start = 1'b0;
   logic        cmd_done = 1'b0;
   logic        card_clk;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sdcard_clkgen u_sdcard_clkgen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .wr_allow(wr_allow), .reg_rdata(reg_rdata), .cmd_start(cmd_start),
      .cmd_done(cmd_done), .card_clk(card_clk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [31:0] d, input logic allow);
      reg_wdata = d;
      wr_allow  = allow;
      reg_wr    = 1'b1;
      tick();
      reg_wr    = 1'b0;
      wr_allow  = 1'b1;
   endtask

   task automatic pulse_start();
      cmd_start = 1'b1;
      tick();
      cmd_start = 1'b0;
   endtask

   task automatic pulse_done();
      cmd_done = 1'b1;
      tick();
      cmd_done = 1'b0;
   endtask

   task automatic wait_rise();
      logic prev;
      int   n;
      prev = card_clk;
      n = 0;
      tick();
      while (!(card_clk && !prev) && n < 3000) begin
         prev = card_clk;
         tick();
         n++;
      end
   endtask

   task automatic measure(output int hi, output int lo);
      int n;
      wait_rise();
      hi = 1;
      n = 0;
      tick();
      while (card_clk && n < 3000) begin hi++; tick(); n++; end
      lo = 1;
      tick();
      while (!card_clk && n < 6000) begin lo++; tick(); n++; end
   endtask

   task automatic count_rises(input int win, output int rises, output int late_hi);
      logic prev;
      prev = card_clk;
      rises = 0;
      late_hi = 0;
      for (int t = 0; t < win; t++) begin
         tick();
         if (card_clk && !prev) rises++;
         if (t >= win - 50 && card_clk) late_hi++;
         prev = card_clk;
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int hi, lo, rises, late, n, k;
      logic [7:0] code;
      logic [7:0] bad_codes [3];
      bad_codes[0] = 8'h03; bad_codes[1] = 8'h81; bad_codes[2] = 8'hFE;

      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(reg_rdata == 32'h20, "R1 reset word", reg_rdata, 32'h20);
      n = 0;
      for (int t = 0; t < 20; t++) begin tick(); if (card_clk) n++; end
      chk(n == 0, "R1 card_clk low after reset", n, 0);

      // R2 layout and reserved bits
      wr(32'hFFFF_FFFF, 1'b1);
      chk(reg_rdata == 32'h3FF, "R2 reserved bits read zero", reg_rdata, 32'h3FF);
      wr(32'hFFFF_FC20, 1'b1);
      chk(reg_rdata == 32'h20, "R2 field placement", reg_rdata, 32'h20);

      // R3 lockout: bits 8:0 held, bit 9 written
      wr(32'h0000_0301, 1'b0);
      chk(reg_rdata == 32'h220, "R3 locked write", reg_rdata, 32'h220);
      wr(32'h0000_0001, 1'b0);
      chk(reg_rdata == 32'h020, "R3 auto bit still writable", reg_rdata, 32'h020);

      // R4 sweep of legal codes
      for (int i = -1; i < 8; i++) begin
         code = (i < 0) ? 8'h00 : (8'h01 << i);
         k = i + 1;
         wr({23'd0, 1'b1, code}, 1'b1);
         measure(hi, lo);
         measure(hi, lo);
         chk(hi == (1 << k), "R4 high phase", hi, 1 << k);
         chk(lo == (1 << k), "R4 low phase", lo, 1 << k);
      end

      // R6 unlisted codes behave as divide by 128
      for (int j = 0; j < 3; j++) begin
         wr({23'd0, 1'b1, bad_codes[j]}, 1'b1);
         measure(hi, lo);
         measure(hi, lo);
         chk(hi == 64 && lo == 64, "R6 unlisted code phases", hi * 1000 + lo, 64064);
      end

      // R5 bypass
      wr(32'h0000_0000, 1'b1);
      repeat (200) tick();
      wr(32'h0000_01FF, 1'b1);
      for (int t = 0; t < 5; t++) begin
         @(posedge clk); #5;
         chk(card_clk == 1'b1, "R5 bypass high with clk", card_clk, 1);
         @(negedge clk); #5;
         chk(card_clk == 1'b0, "R5 bypass low with clk", card_clk, 0);
      end
      tick();
      wr(32'h0000_00FF, 1'b1);
      n = 0;
      for (int t = 0; t < 10; t++) begin @(posedge clk); #5; if (card_clk) n++; end
      chk(n == 0, "R7 bypass disabled stays low", n, 0);
      tick();

      // R11 select change mid high phase
      wr(32'h0000_0080, 1'b1);
      wr(32'h0000_0180, 1'b1);
      measure(hi, lo);
      wait_rise();
      hi = 1;
      repeat (9) begin tick(); if (card_clk) hi++; end
      wr(32'h0000_0100, 1'b1);
      if (card_clk) hi++;
      n = 0;
      tick();
      while (card_clk && n < 1000) begin hi++; tick(); n++; end
      lo = 1;
      tick();
      while (!card_clk && n < 2000) begin lo++; tick(); n++; end
      chk(hi == 256, "R11 old high phase kept", hi, 256);
      chk(lo == 1, "R11 new low phase used", lo, 1);

      // R12 disable mid high phase
      wr(32'h0000_0180, 1'b1);
      measure(hi, lo);
      wait_rise();
      hi = 1;
      repeat (9) begin tick(); if (card_clk) hi++; end
      wr(32'h0000_0080, 1'b1);
      if (card_clk) hi++;
      n = 0;
      tick();
      while (card_clk && n < 1000) begin hi++; tick(); n++; end
      chk(hi == 256, "R12 high phase completes", hi, 256);
      n = 0;
      for (int t = 0; t < 300; t++) begin tick(); if (card_clk) n++; end
      chk(n == 0, "R12 stays low after disable", n, 0);

      // R7 disabled, gating off
      wr(32'h0000_0000, 1'b1);
      n = 0;
      for (int t = 0; t < 40; t++) begin tick(); if (card_clk) n++; end
      chk(n == 0, "R7 disabled output low", n, 0);

      // R8 / R9 auto gating at divide by 4 then by 2
      for (int m = 0; m < 2; m++) begin
         k = (m == 0) ? 1 : 0;
         wr((m == 0) ? 32'h0000_0301 : 32'h0000_0300, 1'b1);
         n = 0;
         for (int t = 0; t < 40; t++) begin tick(); if (card_clk) n++; end
         chk(n == 0, "R8 idle before cmd_start", n, 0);
         pulse_start();
         n = 1;
         while (!card_clk && n < 100) begin tick(); n++; end
         chk(n == (1 << k) + 1, "R8 first rise delay", n, (1 << k) + 1);
         repeat (20) tick();
         pulse_done();
         count_rises(200, rises, late);
         chk(rises == 8, "R9 trailing rising edges", rises, 8);
         chk(late == 0, "R9 low after trail", late, 0);
      end

      // R10 cancel during trail (divide by 2)
      pulse_start();
      repeat (10) tick();
      pulse_done();
      repeat (5) tick();
      pulse_start();
      count_rises(60, rises, late);
      chk(rises >= 29, "R10 clock keeps running", rises, 30);
      pulse_done();
      count_rises(200, rises, late);
      chk(rises == 8, "R10 later stop trails", rises, 8);
      chk(late == 0, "R10 low after later stop", late, 0);

      // R7 disabled with auto gating and a command
      wr(32'h0000_0200, 1'b1);
      pulse_start();
      n = 0;
      for (int t = 0; t < 40; t++) begin tick(); if (card_clk) n++; end
      chk(n == 0, "R7 disabled ignores cmd_start", n, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule